// File: doc/BRIEF.md
# Bus Interface Latch with Preset and Clear

A word-wide, level-sensitive storage latch meant to sit between an internal data path and a shared bus. While the load strobe is high the stored word tracks the data input. When the strobe falls the word is frozen, and later data changes are ignored until the strobe rises again. Two active-low asynchronous overrides act on the stored word: a set that forces all ones and a clear that forces all zeros. The set wins when both are asserted, and data enters only while both overrides are released.

The output stage can pass the stored word unchanged or complement every bit; this is chosen at compile time. It drives the bus only when every one of its active-low enables is low. The pad ring turns the value and drive-enable pair into a real tri-state pin. The word width is a parameter, so a nine-bit build covers a byte plus parity. The number of enables is also a parameter: one enable, or three that are ANDed so several agents can gate the bus.

Top module: `bus_latch_pc`

## Requirements
- R1: With set_n and clr_n both high and load high, the stored word equals the data input, and it changes as soon as the data input changes.
- R2: When load falls with set_n and clr_n high, the word present at that moment is held. Data changes while load stays low leave the stored word unchanged.
- R3: With clr_n low and set_n high, the stored word is all zeros whatever load and the data input do.
- R4: With set_n low, the stored word is all ones whatever load, the data input or clr_n do. The set therefore wins over the clear.
- R5: When the overrides are released while load is high, the latch follows the data input again at once. When they are released while load is low, the forced value is kept.
- R6: q_oe_o is 1 only when every bit of oe_n_i is 0, and 0 otherwise. While the output is floated the stored word still updates, and q_o shows the updated value once it is enabled again.
- R7: With INVERT=1, every bit of q_o is the complement of the stored bit. An active set therefore gives q_o all zeros, and an active clear gives q_o all ones. With INVERT=0, q_o equals the stored word.
- R8: The behaviour of R1 to R7 holds for any WIDTH from 8 to 10 and for NUM_OE of 1 or 3. With NUM_OE=1 the single enable alone gates the drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d_i | input | WIDTH | Data word to be latched |
| load_i | input | 1 | Load strobe: transparent while high, holds on its falling edge |
| clr_n_i | input | 1 | Asynchronous clear to all zeros, active low |
| set_n_i | input | 1 | Asynchronous set to all ones, active low; wins over clear |
| oe_n_i | input | NUM_OE | Active-low output enables; the output drives only when all are low |
| q_o | output | WIDTH | Output word: stored word, complemented when INVERT=1 |
| q_oe_o | output | 1 | Drive enable for the pad; 0 means the pin floats |

## Verification
The case most likely to break is an override change and a load or data change landing together. Examples are set and clear asserted at once, an override released while load is still high, and data moving while the output is floated. The bench applies every combination of enables, overrides and load in a long walking sequence, so each combination is entered from many different previous states. It changes the control pins first and the data a step later, and it judges each step against its own reference state model. Three builds run side by side: nine bits non-inverting, ten bits inverting with one enable, and eight bits inverting with three enables. This way both the complement rule and the enable count are covered by the same stimulus.

// File: rtl/bus_latch_pc_pkg.sv
package bus_latch_pc_pkg;

  // Resolved control for the storage element, one-hot or all zero (hold)
  typedef struct packed {
    logic force_one;
    logic force_zero;
    logic pass;
  } latch_ctl_t;

  // Priority: set over clear over transparent load over hold
  function automatic latch_ctl_t resolve_ctl(input logic set_n,
                                             input logic clr_n,
                                             input logic load);
    latch_ctl_t c;
    c.force_one  = ~set_n;
    c.force_zero = set_n & ~clr_n;
    c.pass       = set_n & clr_n & load;
    return c;
  endfunction

  // Drive only when every active-low enable is low
  function automatic logic all_enabled(input logic [7:0] oe_n_padded);
    return ~|oe_n_padded;
  endfunction

endpackage

// File: rtl/bus_latch_pc_ctl.sv
module bus_latch_pc_ctl
  import bus_latch_pc_pkg::*;
(
  input  logic       set_n_i,
  input  logic       clr_n_i,
  input  logic       load_i,
  output latch_ctl_t ctl_o
);

  always_comb begin
    ctl_o = resolve_ctl(set_n_i, clr_n_i, load_i);
  end

endmodule

// File: rtl/bus_latch_pc_store.sv
module bus_latch_pc_store
  import bus_latch_pc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  latch_ctl_t       ctl_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] st_o
);

  // Level-sensitive storage, one latch per bit
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_latch begin
      if (ctl_i.force_one) begin
        st_o[b] = 1'b1;
      end else if (ctl_i.force_zero) begin
        st_o[b] = 1'b0;
      end else if (ctl_i.pass) begin
        st_o[b] = d_i[b];
      end
    end
  end

endmodule

// File: rtl/bus_latch_pc_drive.sv
module bus_latch_pc_drive
  import bus_latch_pc_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int NUM_OE = 3,
  parameter bit INVERT = 1'b0
) (
  input  logic [WIDTH-1:0]  st_i,
  input  logic [NUM_OE-1:0] oe_n_i,
  output logic [WIDTH-1:0]  q_o,
  output logic              drive_o
);

  localparam int PAD = 8 - NUM_OE;

  if (INVERT) begin : g_inv
    assign q_o = ~st_i;
  end else begin : g_pass
    assign q_o = st_i;
  end

  logic [7:0] oe_n_pad;
  assign oe_n_pad = {{PAD{1'b0}}, oe_n_i};
  assign drive_o  = all_enabled(oe_n_pad);

endmodule

// File: rtl/bus_latch_pc.sv
module bus_latch_pc
  import bus_latch_pc_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int NUM_OE = 3,
  parameter bit INVERT = 1'b0
) (
  input  logic [WIDTH-1:0]  d_i,
  input  logic              load_i,
  input  logic              clr_n_i,
  input  logic              set_n_i,
  input  logic [NUM_OE-1:0] oe_n_i,
  output logic [WIDTH-1:0]  q_o,
  output logic              q_oe_o
);

  // Named internal events, visible to the bound checker
  latch_ctl_t       ctl_w;
  logic [WIDTH-1:0] st_w;
  logic             drive_w;

  bus_latch_pc_ctl u_ctl (
    .set_n_i (set_n_i),
    .clr_n_i (clr_n_i),
    .load_i  (load_i),
    .ctl_o   (ctl_w)
  );

  bus_latch_pc_store #(.WIDTH(WIDTH)) u_store (
    .ctl_i (ctl_w),
    .d_i   (d_i),
    .st_o  (st_w)
  );

  bus_latch_pc_drive #(.WIDTH(WIDTH), .NUM_OE(NUM_OE), .INVERT(INVERT)) u_drive (
    .st_i    (st_w),
    .oe_n_i  (oe_n_i),
    .q_o     (q_o),
    .drive_o (drive_w)
  );

  assign q_oe_o = drive_w;

endmodule

// File: rtl/bus_latch_pc_chk.sv
module bus_latch_pc_chk #(
  parameter int WIDTH  = 8,
  parameter int NUM_OE = 3,
  parameter bit INVERT = 1'b0
) (
  input logic [WIDTH-1:0]  d_i,
  input logic              load_i,
  input logic              clr_n_i,
  input logic              set_n_i,
  input logic [NUM_OE-1:0] oe_n_i,
  input logic [WIDTH-1:0]  st_w,
  input logic [WIDTH-1:0]  q_o,
  input logic              q_oe_o
);

  localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

  always_comb begin
    // R4
    set_wins_chk: assert (set_n_i || st_w == ONES)
      else $error("set active but stored word not all ones");
    // R3
    clear_zero_chk: assert (!set_n_i || clr_n_i || st_w == '0)
      else $error("clear active but stored word not zero");
    // R1
    transparent_chk: assert (!(set_n_i && clr_n_i && load_i) || st_w == d_i)
      else $error("transparent but stored word differs from data");
    // R6
    float_chk: assert ((oe_n_i == '0) == q_oe_o)
      else $error("drive enable disagrees with enables");
    // R7
    set_out_chk: assert (set_n_i || q_o == (INVERT ? '0 : ONES))
      else $error("set active but output word wrong");
    // R7
    clear_out_chk: assert (!set_n_i || clr_n_i || q_o == (INVERT ? ONES : '0))
      else $error("clear active but output word wrong");
  end

endmodule

bind bus_latch_pc bus_latch_pc_chk #(.WIDTH(WIDTH), .NUM_OE(NUM_OE), .INVERT(INVERT)) chk_i (
  .d_i     (d_i),
  .load_i  (load_i),
  .clr_n_i (clr_n_i),
  .set_n_i (set_n_i),
  .oe_n_i  (oe_n_i),
  .st_w    (st_w),
  .q_o     (q_o),
  .q_oe_o  (q_oe_o)
);

// File: tb/bus_latch_pc_tb_top.sv
`timescale 1ns/100ps
module bus_latch_pc_tb_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz pacing clock

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  // Shared stimulus; each build takes the low bits it needs
  logic [9:0] d      = '0;
  logic       load   = 1'b0;
  logic       clr_n  = 1'b1;
  logic       set_n  = 1'b1;
  logic [2:0] oe_n   = 3'b111;

  logic [8:0] qa;  logic qa_oe;   // 9 bit, non-inverting, 3 enables
  logic [9:0] qb;  logic qb_oe;   // 10 bit, inverting, 1 enable
  logic [7:0] qc;  logic qc_oe;   // 8 bit, inverting, 3 enables

  bus_latch_pc #(.WIDTH(9), .NUM_OE(3), .INVERT(1'b0)) dut_i (
    .d_i(d[8:0]), .load_i(load), .clr_n_i(clr_n), .set_n_i(set_n),
    .oe_n_i(oe_n), .q_o(qa), .q_oe_o(qa_oe));

  bus_latch_pc #(.WIDTH(10), .NUM_OE(1), .INVERT(1'b1)) dut_b_i (
    .d_i(d), .load_i(load), .clr_n_i(clr_n), .set_n_i(set_n),
    .oe_n_i(oe_n[0]), .q_o(qb), .q_oe_o(qb_oe));

  bus_latch_pc #(.WIDTH(8), .NUM_OE(3), .INVERT(1'b1)) dut_c_i (
    .d_i(d[7:0]), .load_i(load), .clr_n_i(clr_n), .set_n_i(set_n),
    .oe_n_i(oe_n), .q_o(qc), .q_oe_o(qc_oe));

  // Reference storage, 10 bits wide; narrower builds use the low bits
  logic [9:0] ref_st = '0;
  bit         ref_known = 1'b0;

  function automatic logic [9:0] next_state(input logic [9:0] cur, input logic [9:0] din,
                                             input logic s_n, input logic c_n, input logic ld);
    if (!s_n)      return 10'h3FF;
    else if (!c_n) return 10'h000;
    else if (ld)   return din;
    else           return cur;
  endfunction

  function automatic string tag_of();
    if (!set_n)      return "R4";
    else if (!clr_n) return "R3";
    else if (load)   return "R1";
    else             return "R2";
  endfunction

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [9:0] m9, m10, m8;
    m9  = {1'b0, ref_st[8:0]};
    m10 = ref_st ^ 10'h3FF;
    m8  = {2'b0, ref_st[7:0] ^ 8'hFF};
    chk("R6", {9'b0, qa_oe}, {9'b0, oe_n == 3'b000});
    chk("R8", {9'b0, qb_oe}, {9'b0, !oe_n[0]});
    chk("R6", {9'b0, qc_oe}, {9'b0, oe_n == 3'b000});
    if (ref_known) begin
      chk(tag_of(), {1'b0, qa}, m9);
      chk("R7", qb, m10);
      chk("R7", {2'b0, qc}, m8);
    end
  endtask

  // Controls first, data one step later, sample a step after that
  task automatic apply(input logic [2:0] oe, input logic s_n, input logic c_n,
                       input logic ld, input logic [9:0] din);
    @(negedge clk);
    oe_n = oe; set_n = s_n; clr_n = c_n; load = ld;
    ref_st = next_state(ref_st, d, s_n, c_n, ld);
    if (!s_n || !c_n || ld) ref_known = 1'b1;
    #0.5;
    d = din;
    ref_st = next_state(ref_st, din, s_n, c_n, ld);
    #0.5;
    check_all();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [9:0] lfsr;
    lfsr = 10'h2A5;

    // Reset-like start: clear asserted, outputs floated
    apply(3'b111, 1'b1, 1'b0, 1'b0, 10'h155);   // R3, R6
    // Set and clear together: set wins
    apply(3'b000, 1'b0, 1'b0, 1'b1, 10'h0F0);   // R4, R7

    // R5: release overrides while load high -> follows data at once
    apply(3'b000, 1'b1, 1'b1, 1'b1, 10'h1C3);
    chk("R5", {1'b0, qa}, 10'h1C3);
    // R5: release while load low keeps forced value
    apply(3'b000, 1'b0, 1'b1, 1'b0, 10'h1C3);
    apply(3'b000, 1'b1, 1'b1, 1'b0, 10'h0AA);
    chk("R5", {1'b0, qa}, 10'h1FF);

    // R2: capture on falling load, then data moves
    apply(3'b000, 1'b1, 1'b1, 1'b1, 10'h2B4);
    apply(3'b000, 1'b1, 1'b1, 1'b0, 10'h2B4);
    apply(3'b000, 1'b1, 1'b1, 1'b0, 10'h04B);
    chk("R2", {1'b0, qa}, 10'h0B4);

    // R6: floated, state keeps updating, visible when re-enabled
    apply(3'b010, 1'b1, 1'b1, 1'b1, 10'h133);
    apply(3'b010, 1'b1, 1'b1, 1'b0, 10'h000);
    apply(3'b000, 1'b1, 1'b1, 1'b0, 10'h3CC);
    chk("R6", {1'b0, qa}, 10'h133);

    // Walking sweep over every control combination from many predecessors
    for (int i = 0; i < 1024; i++) begin
      logic [5:0] c;
      c = 6'(i) ^ 6'(i >> 4);
      lfsr = {lfsr[8:0], lfsr[9] ^ lfsr[6]};
      apply(c[5:3], c[2], c[1], c[0], lfsr);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule